// File: doc/BRIEF.md
# Tagged Stack Access Guard

This block decides, one operation at a time, whether a push or a pop may touch stack memory. A small table of stack regions is held inside the guard. Each region has a lower bound, an upper bound and a kind: either a return-address stack or a data stack. Only a caller in kernel mode may write the table. A write made outside kernel mode is refused and reported as a fault.

Each request names a region and gives four things: the operation, the current pointer, whether the register supplying that pointer is tagged as a stack pointer, and whether the word at the target address carries the stack tag. A push first moves the pointer down by one step and uses that new value as its address. A pop uses the pointer as its address and then moves it up by one step. The guard answers one cycle later. A grant carries the access address and the updated pointer. A refusal carries an exception code and returns the pointer unchanged.

Return-address traffic may only use an instruction-kind region and data traffic may only use a data-kind region. As a result, a runaway data stack can never write into the return-address path.

Top module: `stk_guard`

## Requirements
- R1: After reset, rsp_valid, rsp_grant, rsp_code, rsp_addr and rsp_ptr_next are all zero, and every region is unconfigured.
- R2: A table write with cfg_we=1 and kernel_mode=1 stores the base, limit and kind of region cfg_sel. Requests see the new values from the following cycle. A request in the same cycle as the write still sees the old entry.
- R3: A table write with cfg_we=1 and kernel_mode=0 leaves the table unchanged. The next cycle shows rsp_valid=1, rsp_grant=0 and code 3'b101. Any request made in that same cycle is refused with 3'b101.
- R4: A request whose req_sp_tag is 0 is refused with code 3'b001. This check outranks every other request check.
- R5: For req_op[0]=0 (push), the address is req_ptr-STEP and the new pointer equals that address. For req_op[0]=1 (pop), the address is req_ptr and the new pointer is req_ptr+STEP.
- R6: The region must be configured. The address must lie within [base, limit], both ends inclusive. The pointer arithmetic must not wrap past zero or past the top of the address space. If any of these fails, the request is refused with code 3'b010. An unconfigured region is checked right after the stack-pointer tag.
- R7: req_op values 2'b00 (data push) and 2'b01 (data pop) need a region of kind 0 (data). Values 2'b10 (return push) and 2'b11 (return pop) need kind 1 (instruction). A mismatch gives code 3'b100. This check comes after the configured check and before the bounds check.
- R8: If all earlier checks pass but req_mem_tag is 0, the request is refused with code 3'b011.
- R9: Every request or refused table write produces exactly one response, one cycle later. With neither, rsp_valid is 0. rsp_grant=1 exactly when rsp_code is 3'b000. A refusal reports rsp_addr=0 and rsp_ptr_next equal to req_ptr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kernel_mode | input | 1 | High when the caller is the trusted kernel |
| cfg_we | input | 1 | Region table write strobe |
| cfg_sel | input | IDX_W | Region to write |
| cfg_base | input | ADDR_W | Lowest legal stack address |
| cfg_limit | input | ADDR_W | Highest legal stack address |
| cfg_kind | input | 1 | 0 data stack, 1 return-address stack |
| req_valid | input | 1 | Stack operation request |
| req_op | input | 2 | 00 data push, 01 data pop, 10 return push, 11 return pop |
| req_sel | input | IDX_W | Region the operation targets |
| req_sp_tag | input | 1 | Source register carries the stack-pointer tag |
| req_ptr | input | ADDR_W | Current stack pointer |
| req_mem_tag | input | 1 | Target word carries the stack tag |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Operation allowed |
| rsp_code | output | 3 | Exception code, 000 when granted |
| rsp_addr | output | ADDR_W | Address to access when granted |
| rsp_ptr_next | output | ADDR_W | Pointer value after the operation |

## Verification
The temporal properties compare each response with the inputs from one edge earlier. They therefore assume that req_valid and cfg_we stay low while reset is asserted, so that no request can be lost across the release of reset. The stimulus holds every input at zero during reset. It changes inputs only on falling edges, away from the edge that captures them. The table contents are never visible at the ports, so the bench keeps its own copy of what it wrote. It then sweeps every pointer, operation, region and tag combination on a small configuration. Every response is compared with an arithmetic model of the check order.

// File: rtl/stk_guard_pkg.sv
`timescale 1ns/1ps
package stk_guard_pkg;
   typedef enum logic [1:0] {
      OP_DPUSH = 2'b00,
      OP_DPOP  = 2'b01,
      OP_RPUSH = 2'b10,
      OP_RPOP  = 2'b11
   } stk_op_e;

   typedef enum logic [2:0] {
      EXC_NONE      = 3'b000,
      EXC_NO_SP     = 3'b001,
      EXC_RANGE     = 3'b010,
      EXC_NOT_STACK = 3'b011,
      EXC_KIND      = 3'b100,
      EXC_PRIV      = 3'b101
   } stk_exc_e;

   localparam logic KIND_DATA  = 1'b0;
   localparam logic KIND_INSTR = 1'b1;
endpackage

// File: rtl/stk_region_file.sv
`timescale 1ns/1ps
module stk_region_file #(
   parameter int ADDR_W = 12,
   parameter int N_STK  = 4,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_sel,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_limit,
   input  logic              wr_kind,
   input  logic [IDX_W-1:0]  rd_sel,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_base,
   output logic [ADDR_W-1:0] rd_limit,
   output logic              rd_kind
);
   logic [N_STK-1:0]             valid_all;
   logic [N_STK-1:0]             kind_all;
   logic [N_STK-1:0][ADDR_W-1:0] base_all;
   logic [N_STK-1:0][ADDR_W-1:0] limit_all;

   for (genvar g = 0; g < N_STK; g++) begin : g_rgn
      logic              vld_q;
      logic              kind_q;
      logic [ADDR_W-1:0] base_q;
      logic [ADDR_W-1:0] limit_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q   <= 1'b0;
            kind_q  <= 1'b0;
            base_q  <= '0;
            limit_q <= '0;
         end else if (wr_en && (wr_sel == IDX_W'(g))) begin
            vld_q   <= 1'b1;
            kind_q  <= wr_kind;
            base_q  <= wr_base;
            limit_q <= wr_limit;
         end
      end

      assign valid_all[g] = vld_q;
      assign kind_all[g]  = kind_q;
      assign base_all[g]  = base_q;
      assign limit_all[g] = limit_q;
   end

   always_comb begin
      rd_valid = 1'b0;
      rd_kind  = 1'b0;
      rd_base  = '0;
      rd_limit = '0;
      for (int i = 0; i < N_STK; i++) begin
         if (rd_sel == IDX_W'(i)) begin
            rd_valid = valid_all[i];
            rd_kind  = kind_all[i];
            rd_base  = base_all[i];
            rd_limit = limit_all[i];
         end
      end
   end
endmodule

// File: rtl/stk_addr_calc.sv
`timescale 1ns/1ps
module stk_addr_calc #(
   parameter int ADDR_W = 12,
   parameter int STEP   = 1
) (
   input  logic              is_pop,
   input  logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] ptr_next,
   output logic              wrapped
);
   localparam logic [ADDR_W:0] STEP_X = (ADDR_W+1)'(STEP);

   logic [ADDR_W:0] down_x;
   logic [ADDR_W:0] up_x;

   assign down_x = {1'b0, ptr} - STEP_X;
   assign up_x   = {1'b0, ptr} + STEP_X;

   always_comb begin
      if (is_pop) begin
         acc_addr = ptr;
         ptr_next = up_x[ADDR_W-1:0];
         wrapped  = up_x[ADDR_W];
      end else begin
         acc_addr = down_x[ADDR_W-1:0];
         ptr_next = down_x[ADDR_W-1:0];
         wrapped  = down_x[ADDR_W];
      end
   end
endmodule

// File: rtl/stk_rule_check.sv
`timescale 1ns/1ps
module stk_rule_check
   import stk_guard_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              sp_tag,
   input  logic              mem_tag,
   input  logic [1:0]        op,
   input  logic              rgn_valid,
   input  logic              rgn_kind,
   input  logic [ADDR_W-1:0] rgn_base,
   input  logic [ADDR_W-1:0] rgn_limit,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wrapped,
   output stk_exc_e          code
);
   logic wants_instr;
   logic outside;

   assign wants_instr = op[1];
   assign outside     = wrapped || (addr < rgn_base) || (addr > rgn_limit);

   always_comb begin
      if (!sp_tag)                        code = EXC_NO_SP;
      else if (!rgn_valid)                code = EXC_RANGE;
      else if (wants_instr != rgn_kind)   code = EXC_KIND;
      else if (outside)                   code = EXC_RANGE;
      else if (!mem_tag)                  code = EXC_NOT_STACK;
      else                                code = EXC_NONE;
   end
endmodule

// File: rtl/stk_guard.sv
`timescale 1ns/1ps
module stk_guard
   import stk_guard_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int N_STK  = 4,
   parameter int STEP   = 1,
   localparam int IDX_W = (N_STK > 1) ? $clog2(N_STK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kernel_mode,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_limit,
   input  logic              cfg_kind,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [IDX_W-1:0]  req_sel,
   input  logic              req_sp_tag,
   input  logic [ADDR_W-1:0] req_ptr,
   input  logic              req_mem_tag,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic [2:0]        rsp_code,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [ADDR_W-1:0] rsp_ptr_next
);
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("stk_guard: ADDR_W must be at least 4");
   end
   if (N_STK < 2) begin : g_bad_n_stk
      $error("stk_guard: N_STK must be at least 2");
   end
   if ((STEP < 1) || (STEP >= (1 << (ADDR_W - 1)))) begin : g_bad_step
      $error("stk_guard: STEP out of range for ADDR_W");
   end

   logic              priv_fault;
   logic              tbl_wr;
   logic              rgn_valid;
   logic              rgn_kind;
   logic [ADDR_W-1:0] rgn_base;
   logic [ADDR_W-1:0] rgn_limit;
   logic [ADDR_W-1:0] acc_addr;
   logic [ADDR_W-1:0] nxt_ptr;
   logic              wrapped;
   stk_exc_e          chk_code;

   assign priv_fault = cfg_we && !kernel_mode;
   assign tbl_wr     = cfg_we && kernel_mode;

   stk_region_file #(
      .ADDR_W (ADDR_W),
      .N_STK  (N_STK),
      .IDX_W  (IDX_W)
   ) rgn_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_wr),
      .wr_sel   (cfg_sel),
      .wr_base  (cfg_base),
      .wr_limit (cfg_limit),
      .wr_kind  (cfg_kind),
      .rd_sel   (req_sel),
      .rd_valid (rgn_valid),
      .rd_base  (rgn_base),
      .rd_limit (rgn_limit),
      .rd_kind  (rgn_kind)
   );

   stk_addr_calc #(
      .ADDR_W (ADDR_W),
      .STEP   (STEP)
   ) calc_i (
      .is_pop   (req_op[0]),
      .ptr      (req_ptr),
      .acc_addr (acc_addr),
      .ptr_next (nxt_ptr),
      .wrapped  (wrapped)
   );

   stk_rule_check #(
      .ADDR_W (ADDR_W)
   ) rule_i (
      .sp_tag    (req_sp_tag),
      .mem_tag   (req_mem_tag),
      .op        (req_op),
      .rgn_valid (rgn_valid),
      .rgn_kind  (rgn_kind),
      .rgn_base  (rgn_base),
      .rgn_limit (rgn_limit),
      .addr      (acc_addr),
      .wrapped   (wrapped),
      .code      (chk_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_grant    <= 1'b0;
         rsp_code     <= EXC_NONE;
         rsp_addr     <= '0;
         rsp_ptr_next <= '0;
      end else if (priv_fault) begin
         rsp_valid    <= 1'b1;
         rsp_grant    <= 1'b0;
         rsp_code     <= EXC_PRIV;
         rsp_addr     <= '0;
         rsp_ptr_next <= req_ptr;
      end else if (req_valid) begin
         rsp_valid    <= 1'b1;
         rsp_grant    <= (chk_code == EXC_NONE);
         rsp_code     <= chk_code;
         rsp_addr     <= (chk_code == EXC_NONE) ? acc_addr : '0;
         rsp_ptr_next <= (chk_code == EXC_NONE) ? nxt_ptr : req_ptr;
      end else begin
         rsp_valid    <= 1'b0;
         rsp_grant    <= 1'b0;
         rsp_code     <= EXC_NONE;
         rsp_addr     <= '0;
         rsp_ptr_next <= '0;
      end
   end
endmodule

// File: rtl/stk_guard_chk.sv
`timescale 1ns/1ps
module stk_guard_chk #(
   parameter int ADDR_W = 12,
   parameter int N_STK  = 4,
   parameter int STEP   = 1,
   parameter int IDX_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              kernel_mode,
   input logic              cfg_we,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic              req_sp_tag,
   input logic [ADDR_W-1:0] req_ptr,
   input logic              req_mem_tag,
   input logic              rsp_valid,
   input logic              rsp_grant,
   input logic [2:0]        rsp_code,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic [ADDR_W-1:0] rsp_ptr_next
);
   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

   // R9
   rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid || (cfg_we && !kernel_mode)));

   // R9
   cause_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid || (cfg_we && !kernel_mode)) |=> rsp_valid);

   // R9
   grant_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_grant == (rsp_code == 3'b000)));

   // R9
   deny_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_grant || (rsp_ptr_next == $past(req_ptr) && rsp_addr == '0)));

   // R3
   priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !kernel_mode) |=> (rsp_valid && !rsp_grant && rsp_code == 3'b101));

   // R4
   no_sp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_sp_tag && !(cfg_we && !kernel_mode)) |=> (rsp_code == 3'b001));

   // R8
   mem_tag_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_mem_tag) |=> !rsp_grant);

   // R5
   push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_op[0]) |=>
         (!rsp_grant || (rsp_addr == $past(req_ptr) - STEP_A && rsp_ptr_next == rsp_addr)));

   // R5
   pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op[0]) |=>
         (!rsp_grant || (rsp_addr == $past(req_ptr) && rsp_ptr_next == $past(req_ptr) + STEP_A)));
endmodule

bind stk_guard stk_guard_chk #(
   .ADDR_W (ADDR_W),
   .N_STK  (N_STK),
   .STEP   (STEP),
   .IDX_W  (IDX_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .kernel_mode  (kernel_mode),
   .cfg_we       (cfg_we),
   .req_valid    (req_valid),
   .req_op       (req_op),
   .req_sp_tag   (req_sp_tag),
   .req_ptr      (req_ptr),
   .req_mem_tag  (req_mem_tag),
   .rsp_valid    (rsp_valid),
   .rsp_grant    (rsp_grant),
   .rsp_code     (rsp_code),
   .rsp_addr     (rsp_addr),
   .rsp_ptr_next (rsp_ptr_next)
);

// File: tb/stk_guard_tb_top.sv
`timescale 1ns/1ps
module stk_guard_tb_top;
   localparam int AW   = 6;
   localparam int NS   = 2;
   localparam int ST   = 2;
   localparam int IW   = 1;
   localparam int AMAX = (1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          kernel_mode = 1'b0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_sel = '0;
   logic [AW-1:0] cfg_base = '0;
   logic [AW-1:0] cfg_limit = '0;
   logic          cfg_kind = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic [IW-1:0] req_sel = '0;
   logic          req_sp_tag = 1'b0;
   logic [AW-1:0] req_ptr = '0;
   logic          req_mem_tag = 1'b0;
   logic          rsp_valid;
   logic          rsp_grant;
   logic [2:0]    rsp_code;
   logic [AW-1:0] rsp_addr;
   logic [AW-1:0] rsp_ptr_next;

   int n_cmp = 0;
   int n_bad = 0;

   int m_base [NS];
   int m_lim  [NS];
   int m_kind [NS];
   int m_vld  [NS];

   always #2 clk = ~clk;

   stk_guard #(.ADDR_W(AW), .N_STK(NS), .STEP(ST)) dut_i (
      .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
      .cfg_limit(cfg_limit), .cfg_kind(cfg_kind),
      .req_valid(req_valid), .req_op(req_op), .req_sel(req_sel),
      .req_sp_tag(req_sp_tag), .req_ptr(req_ptr), .req_mem_tag(req_mem_tag),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_code(rsp_code),
      .rsp_addr(rsp_addr), .rsp_ptr_next(rsp_ptr_next)
   );

   task automatic compare(input string tag, input int v, input int g, input int c,
                          input int a, input int n);
      n_cmp++;
      if (rsp_valid !== v[0] || rsp_grant !== g[0] || rsp_code !== c[2:0] ||
          rsp_addr !== a[AW-1:0] || rsp_ptr_next !== n[AW-1:0]) begin
         n_bad++;
         $display("FAIL %s: actual v=%0d g=%0d code=%0d addr=%0d next=%0d expected v=%0d g=%0d code=%0d addr=%0d next=%0d",
                  tag, rsp_valid, rsp_grant, rsp_code, rsp_addr, rsp_ptr_next, v, g, c, a, n);
      end
   endtask

   function automatic int model_code(input int sel, input int op, input int sp,
                                     input int mt, input int ptr, output int addr,
                                     output int nxt);
      int a, n, code;
      bit wrap;
      if (op % 2 == 0) begin
         a = ptr - ST; n = a; wrap = (a < 0);
      end else begin
         a = ptr; n = ptr + ST; wrap = (n > AMAX);
      end
      if (sp == 0)                           code = 1;
      else if (m_vld[sel] == 0)              code = 2;
      else if ((op >= 2 ? 1 : 0) != m_kind[sel]) code = 4;
      else if (wrap || a < m_base[sel] || a > m_lim[sel]) code = 2;
      else if (mt == 0)                      code = 3;
      else                                   code = 0;
      addr = (code == 0) ? a : 0;
      nxt  = (code == 0) ? (n & AMAX) : ptr;
      return code;
   endfunction

   function automatic string code_tag(input int code);
      case (code)
         1: return "R4";
         2: return "R6";
         3: return "R8";
         4: return "R7";
         default: return "R5";
      endcase
   endfunction

   // called at a falling edge; returns at the next falling edge
   task automatic cfg_write(input int sel, input int base, input int lim,
                            input int kind, input int kern);
      cfg_we = 1'b1; kernel_mode = kern[0]; cfg_sel = sel[IW-1:0];
      cfg_base = base[AW-1:0]; cfg_limit = lim[AW-1:0]; cfg_kind = kind[0];
      @(posedge clk); #1;
      if (kern != 0) begin
         m_base[sel] = base; m_lim[sel] = lim; m_kind[sel] = kind; m_vld[sel] = 1;
         compare("R2 legal write alone gives no response", 0, 0, 0, 0, 0);
      end else begin
         compare("R3 write outside kernel mode", 1, 0, 5, 0, int'(req_ptr));
      end
      @(negedge clk);
      cfg_we = 1'b0; kernel_mode = 1'b0;
   endtask

   task automatic request(input string tag, input int sel, input int op, input int sp,
                          input int mt, input int ptr);
      int ea, en, ec;
      ec = model_code(sel, op, sp, mt, ptr, ea, en);
      req_valid = 1'b1; req_sel = sel[IW-1:0]; req_op = op[1:0];
      req_sp_tag = sp[0]; req_mem_tag = mt[0]; req_ptr = ptr[AW-1:0];
      @(posedge clk); #1;
      compare(tag.len() == 0 ? code_tag(ec) : tag, 1, (ec == 0) ? 1 : 0, ec, ea, en);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NS; i++) begin
         m_base[i] = 0; m_lim[i] = 0; m_kind[i] = 0; m_vld[i] = 0;
      end
      repeat (3) @(negedge clk);
      #1;
      compare("R1 outputs during reset", 0, 0, 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      compare("R1 outputs after reset release", 0, 0, 0, 0, 0);
      @(negedge clk);

      // R1: regions start unconfigured
      request("R1 region 0 unconfigured", 0, 1, 1, 1, 20);
      request("R1 region 1 unconfigured", 1, 2, 1, 1, 50);

      // R3: refused write, concurrent request denied, table untouched
      req_valid = 1'b1; req_sel = '0; req_op = 2'b01; req_sp_tag = 1'b1;
      req_mem_tag = 1'b1; req_ptr = 6'd20;
      cfg_write(0, 8, 40, 0, 0);
      req_valid = 1'b0;
      request("R3 table unchanged after refused write", 0, 1, 1, 1, 20);

      // R2: same-cycle request sees the old entry, next cycle the new one
      cfg_we = 1'b1; kernel_mode = 1'b1; cfg_sel = '0;
      cfg_base = 6'd8; cfg_limit = 6'd40; cfg_kind = 1'b0;
      req_valid = 1'b1; req_sel = '0; req_op = 2'b01; req_sp_tag = 1'b1;
      req_mem_tag = 1'b1; req_ptr = 6'd20;
      @(posedge clk); #1;
      compare("R2 same-cycle request sees old entry", 1, 0, 2, 0, 20);
      m_base[0] = 8; m_lim[0] = 40; m_kind[0] = 0; m_vld[0] = 1;
      @(negedge clk);
      cfg_we = 1'b0; kernel_mode = 1'b0; req_valid = 1'b0;
      request("R2 new entry in effect", 0, 1, 1, 1, 20);
      cfg_write(1, 44, 60, 1, 1);

      // R9: idle cycle
      @(posedge clk); #1;
      compare("R9 idle gives no response", 0, 0, 0, 0, 0);
      @(negedge clk);

      // exhaustive sweep over region, op, tags and pointer
      for (int s = 0; s < NS; s++)
         for (int op = 0; op < 4; op++)
            for (int t = 0; t < 4; t++)
               for (int p = 0; p <= AMAX; p++)
                  request("", s, op, t / 2, t % 2, p);

      // R6 wrap corners with full-range data region
      cfg_write(1, 0, AMAX, 0, 1);
      request("R6 push below zero wraps", 1, 0, 1, 1, 0);
      request("R6 push to address zero allowed", 1, 0, 1, 1, 2);
      request("R6 pop past top wraps", 1, 1, 1, 1, 62);
      request("R6 pop near top allowed", 1, 1, 1, 1, 61);
      request("R7 return push on data region", 1, 2, 1, 1, 30);

      // R6 inverted bounds deny everything
      cfg_write(0, 30, 10, 0, 1);
      request("R6 inverted bounds push", 0, 0, 1, 1, 20);
      request("R6 inverted bounds pop", 0, 1, 1, 1, 20);

      // R4 dominates kind and tag faults
      request("R4 missing sp tag outranks others", 0, 3, 0, 0, 63);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule